// File: doc/BRIEF.md
# Cycle Counter with Limit Match Interrupt

The block keeps three independent 63-bit cycle counters, each paired with a compare value. A shared tick-enable input advances all counters by one. When a counter steps onto its compare value, the channel raises a one-cycle match pulse. That pulse is the request to set a software-interrupt bit kept elsewhere. Channel 0 is the plain tick timer and drives the timer interrupt pulse. Channels 1 and 2 are the system and hypervisor system timers, and they share the system-timer interrupt pulse.

Software reaches each channel through a simple register port. A channel select picks the channel and a register select picks count or limit. Writes take one cycle and reads are combinational. Each 64-bit register carries a control flag in its top bit. On the count register that bit is a flag that blocks unprivileged reads. On the limit register it disables the interrupt. The counter itself uses only the low 63 bits.

Once a match has fired, the channel does not fire again until software rewrites its limit or its count. A limit of zero is never armed. A limit written at or behind the current count fires on the very next tick, so late programming cannot lose an interrupt.

Top module: `tick_compare_unit`

## Requirements
- R1: After reset, every channel reads count 64'h8000_0000_0000_0000 and limit 64'h8000_0000_0000_0000, which means both flags are 1 and both values are 0. Neither interrupt pulse is raised.
- R2: A count write (reg_sel=0) loads bits 62:0 into the counter and bit 63 into the unprivileged-read flag. A count read returns the counter in bits 62:0 and the flag in bit 63.
- R3: A limit write (reg_sel=1) stores bits 62:0 as the compare value and bit 63 as the interrupt-disable flag. A limit read returns them in the same positions.
- R4: Each rising edge with tick_en high adds one to every counter, and 2^63-1 wraps to 0. Without tick_en, the counters hold.
- R5: A tick that moves an armed, enabled counter onto its compare value gives a match pulse. The pulse is high for exactly the cycle after that edge, and in that cycle the count reads the compare value.
- R6: After a match, the channel stays quiet on later ticks until its limit or its count is written again. A count write re-arms the channel when the compare value is non-zero.
- R7: A compare value of zero never produces a match.
- R8: While the disable flag is 1, no match is produced.
- R9: If a limit write stores a non-zero compare value that is less than or equal to the count after that edge, the match fires on the next tick.
- R10: Channel 0 drives tick_irq_set. Channels 1 and 2 both drive sys_irq_set, and a match on both in the same tick gives a single pulse.
- R11: reg_chan 0, 1 and 2 select the tick, system and hypervisor channels. A write to reg_chan 3 is ignored and a read of it returns 0. A count write in the same cycle as a tick loads the written value with no increment. A limit write in the same cycle as a tick does not fire that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Advance all counters by one on this edge |
| reg_wr | input | 1 | Register write strobe |
| reg_chan | input | 2 | Channel select: 0 tick, 1 system, 2 hypervisor system |
| reg_sel | input | 1 | Register select: 0 count, 1 limit |
| reg_wdata | input | 64 | Write data, bit 63 is the register's flag |
| reg_rdata | output | 64 | Read data for the selected register |
| tick_irq_set | output | 1 | One-cycle pulse that sets the timer interrupt bit |
| sys_irq_set | output | 1 | One-cycle pulse that sets the system-timer interrupt bit |

## Verification
The hardest case is the counter wrapping from 2^63-1 to zero into a match. Ticking there from reset is out of reach. The stimulus writes the limit first and then loads the count just below the wrap point. The count write clears the late condition that the limit write had set. A reference model in the bench mirrors every write and tick, so each pulse is expected on an exact cycle. The other hard case is two system channels matching on the same tick. It is reached by programming both limits to one value after loading both counts to one value.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int TICK_W = 64;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } tick_sel_e;
endpackage

// File: rtl/tick_counter.sv
// Counter part of one channel: 63-bit up counter plus the read-blocking flag
module tick_counter #(
  parameter int W = tick_pkg::TICK_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           load_en,
  input  logic [W-1:0]   load_val,
  output logic [W-2:0]   cnt_next,
  output logic [W-1:0]   rd_val
);
  localparam int LW = W - 1;

  logic [LW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          cnt_upd;

  always_comb begin
    cnt_d   = cnt_q;
    flag_d  = flag_q;
    cnt_upd = load_en | tick_en;
    if (load_en) begin
      cnt_d  = load_val[LW-1:0];
      flag_d = load_val[W-1];
    end else if (tick_en) begin
      cnt_d = cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      if (load_en) flag_q <= flag_d;
    end
  end

  assign cnt_next = cnt_d;
  assign rd_val   = {flag_q, cnt_q};
endmodule

// File: rtl/tick_limit_arm.sv
// Compare part of one channel: limit value, disable flag, arming and late-write state
module tick_limit_arm #(
  parameter int W = tick_pkg::TICK_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           lim_wr,
  input  logic           cnt_wr,
  input  logic [W-1:0]   wval,
  input  logic [W-2:0]   cnt_next,
  output logic [W-1:0]   rd_val,
  output logic           dis,
  output logic           fire
);
  localparam int LW = W - 1;

  logic [LW-1:0] cmp_q, cmp_d;
  logic          dis_q, dis_d;
  logic          armed_q, armed_d;
  logic          late_q, late_d;
  logic          fire_q, fire_c;
  logic          st_upd;

  always_comb begin
    fire_c  = tick_en & ~lim_wr & ~cnt_wr & armed_q & ~dis_q &
              (late_q | (cnt_next == cmp_q));
    cmp_d   = cmp_q;
    dis_d   = dis_q;
    armed_d = armed_q;
    late_d  = late_q;
    st_upd  = lim_wr | cnt_wr | fire_c;
    if (lim_wr) begin
      cmp_d   = wval[LW-1:0];
      dis_d   = wval[W-1];
      armed_d = (wval[LW-1:0] != '0);
      late_d  = (wval[LW-1:0] <= cnt_next);
    end else if (cnt_wr) begin
      armed_d = (cmp_q != '0);
      late_d  = 1'b0;
    end else if (fire_c) begin
      armed_d = 1'b0;
      late_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= fire_c;
      if (st_upd) begin
        cmp_q   <= cmp_d;
        dis_q   <= dis_d;
        armed_q <= armed_d;
        late_q  <= late_d;
      end
    end
  end

  assign rd_val = {dis_q, cmp_q};
  assign dis    = dis_q;
  assign fire   = fire_q;
endmodule

// File: rtl/tick_channel.sv
module tick_channel #(
  parameter int W = tick_pkg::TICK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         cnt_wr,
  input  logic         lim_wr,
  input  logic [W-1:0] wval,
  output logic [W-1:0] rd_cnt,
  output logic [W-1:0] rd_lim,
  output logic         dis,
  output logic         fire
);
  logic [W-2:0] cnt_next;

  tick_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_en  (cnt_wr),
    .load_val (wval),
    .cnt_next (cnt_next),
    .rd_val   (rd_cnt)
  );

  tick_limit_arm #(.W(W)) u_lim (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .lim_wr   (lim_wr),
    .cnt_wr   (cnt_wr),
    .wval     (wval),
    .cnt_next (cnt_next),
    .rd_val   (rd_lim),
    .dis      (dis),
    .fire     (fire)
  );
endmodule

// File: rtl/tick_compare_unit.sv
module tick_compare_unit #(
  parameter int               NUM_CH   = 3,
  parameter int               W        = tick_pkg::TICK_W,
  parameter logic [NUM_CH-1:0] SYS_MASK = 3'b110,
  localparam int              CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            reg_wr,
  input  logic [CH_W-1:0] reg_chan,
  input  logic            reg_sel,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  output logic            tick_irq_set,
  output logic            sys_irq_set
);
  import tick_pkg::*;

  logic              rst_meta, rst_sync_n;
  logic [NUM_CH-1:0] ch_fire, ch_dis;
  logic [W-1:0]      rd_cnt [NUM_CH];
  logic [W-1:0]      rd_lim [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = reg_wr && (reg_chan == CH_W'(i));

    tick_channel #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick_en (tick_en),
      .cnt_wr  (hit && (reg_sel == SEL_COUNT)),
      .lim_wr  (hit && (reg_sel == SEL_LIMIT)),
      .wval    (reg_wdata),
      .rd_cnt  (rd_cnt[i]),
      .rd_lim  (rd_lim[i]),
      .dis     (ch_dis[i]),
      .fire    (ch_fire[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_chan == CH_W'(i)) begin
        reg_rdata = (reg_sel == SEL_LIMIT) ? rd_lim[i] : rd_cnt[i];
      end
    end
  end

  assign tick_irq_set = |(ch_fire & ~SYS_MASK);
  assign sys_irq_set  = |(ch_fire & SYS_MASK);
endmodule

// File: rtl/tick_compare_unit_chk.sv
module tick_compare_unit_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [NUM_CH-1:0] fire_vec,
  input logic [NUM_CH-1:0] dis_vec,
  input logic              tick_irq_set,
  input logic              sys_irq_set
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!tick_irq_set && !sys_irq_set);
    end
  end

  // R5
  fire_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_irq_set || sys_irq_set) |-> $past(tick_en));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq_set |=> !tick_irq_set);

  // R8
  no_dis_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_vec) |-> ((fire_vec & $past(dis_vec)) == '0));
endmodule

bind tick_compare_unit tick_compare_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick_en      (tick_en),
  .fire_vec     (ch_fire),
  .dis_vec      (ch_dis),
  .tick_irq_set (tick_irq_set),
  .sys_irq_set  (sys_irq_set)
);

// File: tb/tick_compare_unit_test.sv
module tick_compare_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        reg_wr;
  logic [1:0]  reg_chan;
  logic        reg_sel;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        tick_irq_set;
  logic        sys_irq_set;

  int total = 0;
  int bad   = 0;
  int dcyc  = 0;
  int mcyc  = 0;

  typedef struct {int cyc; bit t; bit s;} ev_t;
  ev_t exp_q[$];

  logic [62:0] mc   [3];
  logic [62:0] mcmp [3];
  bit          mnpt [3];
  bit          mdis [3];
  bit          marm [3];
  bit          mlate[3];

  tick_compare_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .reg_wr       (reg_wr),
    .reg_chan     (reg_chan),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .tick_irq_set (tick_irq_set),
    .sys_irq_set  (sys_irq_set)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired, R5 run did not complete (actual hung, expected done)");
    finish_run();
  end

  // monitor: pops expected pulses and compares cycle and kind
  always @(negedge clk) begin
    mcyc++;
    if (exp_q.size() > 0 && exp_q[0].cyc < mcyc) begin
      total++;
      bad++;
      $display("FAIL R5 missing pulse at cycle %0d: actual none, expected t=%0d s=%0d",
               exp_q[0].cyc, exp_q[0].t, exp_q[0].s);
      void'(exp_q.pop_front());
    end
    if (tick_irq_set || sys_irq_set) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6/R7/R8 unexpected pulse at cycle %0d: actual t=%0d s=%0d, expected none",
                 mcyc, tick_irq_set, sys_irq_set);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.cyc != mcyc || e.t != tick_irq_set || e.s != sys_irq_set) begin
          bad++;
          $display("FAIL %s pulse: actual cyc=%0d t=%0d s=%0d, expected cyc=%0d t=%0d s=%0d",
                   e.s ? "R10" : "R5", mcyc, tick_irq_set, sys_irq_set, e.cyc, e.t, e.s);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    dcyc++;
  endtask

  // reference model for one tick; skip_ch holds its count, nofire_ch cannot match
  task automatic m_tick(input int skip_ch, input int nofire_ch);
    bit t = 0;
    bit s = 0;
    for (int ch = 0; ch < 3; ch++) begin
      if (ch != skip_ch) begin
        logic [62:0] nxt;
        nxt = mc[ch] + 63'd1;
        if (ch != nofire_ch && marm[ch] && !mdis[ch] && (mlate[ch] || nxt == mcmp[ch])) begin
          marm[ch]  = 0;
          mlate[ch] = 0;
          if (ch == 0) t = 1; else s = 1;
        end
        mc[ch] = nxt;
      end
    end
    if (t || s) exp_q.push_back('{cyc: dcyc + 1, t: t, s: s});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      m_tick(-1, -1);
      step();
    end
    tick_en = 1'b0;
  endtask

  task automatic wr(input int ch, input bit sel, input logic [63:0] v, input bit tk);
    reg_chan  = 2'(ch);
    reg_sel   = sel;
    reg_wdata = v;
    reg_wr    = 1'b1;
    tick_en   = tk;
    if (tk) begin
      if (ch < 3 && !sel) m_tick(ch, -1);
      else if (ch < 3) m_tick(-1, ch);
      else m_tick(-1, -1);
    end
    if (ch < 3) begin
      if (!sel) begin
        mc[ch]    = v[62:0];
        mnpt[ch]  = v[63];
        marm[ch]  = (mcmp[ch] != 0);
        mlate[ch] = 0;
      end else begin
        mcmp[ch]  = v[62:0];
        mdis[ch]  = v[63];
        marm[ch]  = (v[62:0] != 0);
        mlate[ch] = (v[62:0] <= mc[ch]);
      end
    end
    step();
    reg_wr  = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic rd_chk(input int ch, input bit sel, input logic [63:0] expv, input string req);
    reg_chan = 2'(ch);
    reg_sel  = sel;
    #2;
    total++;
    if (reg_rdata !== expv) begin
      bad++;
      $display("FAIL %s read ch=%0d sel=%0d: actual %h, expected %h", req, ch, sel, reg_rdata, expv);
    end
  endtask

  function automatic logic [63:0] m_cnt(input int ch);
    return {mnpt[ch], mc[ch]};
  endfunction

  function automatic logic [63:0] m_lim(input int ch);
    return {mdis[ch], mcmp[ch]};
  endfunction

  initial begin
    rst_n     = 1'b0;
    tick_en   = 1'b0;
    reg_wr    = 1'b0;
    reg_chan  = 2'd0;
    reg_sel   = 1'b0;
    reg_wdata = '0;
    for (int ch = 0; ch < 3; ch++) begin
      mc[ch] = '0; mcmp[ch] = '0; mnpt[ch] = 1; mdis[ch] = 1; marm[ch] = 0; mlate[ch] = 0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state of every channel
    for (int ch = 0; ch < 3; ch++) begin
      rd_chk(ch, 0, 64'h8000_0000_0000_0000, "R1");
      rd_chk(ch, 1, 64'h8000_0000_0000_0000, "R1");
    end

    // R11 channel 3 is not a channel
    wr(3, 0, 64'd77, 0);
    rd_chk(3, 0, 64'd0, "R11");
    rd_chk(0, 0, 64'h8000_0000_0000_0000, "R11");

    // R2 count write and flag in bit 63
    wr(0, 0, 64'h8000_0000_0000_000A, 0);
    rd_chk(0, 0, 64'h8000_0000_0000_000A, "R2");
    wr(0, 0, 64'd5, 0);
    rd_chk(0, 0, 64'd5, "R2");

    // R3 limit write, R5 match on the third tick
    wr(0, 1, 64'd8, 0);
    rd_chk(0, 1, 64'd8, "R3");
    ticks(3);
    rd_chk(0, 0, 64'd8, "R5");

    // R6 no re-fire, R4 counting continues
    ticks(4);
    rd_chk(0, 0, 64'd12, "R4");

    // R7 zero compare
    wr(0, 1, 64'd0, 0);
    ticks(3);
    rd_chk(0, 1, 64'd0, "R7");

    // R8 disabled
    wr(0, 1, {1'b1, mc[0] + 63'd2}, 0);
    rd_chk(0, 1, m_lim(0), "R3");
    ticks(4);
    rd_chk(0, 0, m_cnt(0), "R8");

    // R9 behind and equal
    wr(0, 1, {1'b0, mc[0] - 63'd9}, 0);
    ticks(1);
    wr(0, 1, {1'b0, mc[0]}, 0);
    ticks(2);

    // R11 count write wins over a tick in the same cycle
    wr(0, 0, 64'd100, 1);
    rd_chk(0, 0, 64'd100, "R11");

    // R10 system channels share one pulse
    wr(1, 0, 64'd0, 0);
    wr(2, 0, 64'd0, 0);
    wr(1, 1, 64'd2, 0);
    wr(2, 1, 64'd4, 0);
    ticks(2);
    ticks(2);
    rd_chk(2, 0, 64'd4, "R10");
    wr(1, 1, 64'd6, 0);
    wr(2, 1, 64'd6, 0);
    ticks(3);

    // R4 wrap into R5 match
    wr(0, 1, 64'd1, 0);
    wr(0, 0, 64'h7FFF_FFFF_FFFF_FFFE, 0);
    ticks(2);
    rd_chk(0, 0, 64'd0, "R4");
    ticks(1);
    rd_chk(0, 0, 64'd1, "R5");

    // R4 hold without tick_en
    repeat (3) step();
    rd_chk(0, 0, 64'd1, "R4");

    repeat (4) step();
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5 pending pulses: actual %0d left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule